// File: doc/BRIEF.md
# Video Filter Configuration Register Slave (I2C, write-only)

This block is the control-side front end of a three-channel video filter device. It watches the two I2C bus lines through synchronisers running on the system clock. It accepts only one kind of frame: START, device address with the write bit, register index, one data byte, STOP. The data byte is placed into one of three configuration registers. The registers drive the analog side directly: the filter cutoff code, a per-channel input coupling type, the output gain, power-down, half-cutoff and filter-bypass controls, and the input multiplexer select.

The device address comes from a pre-resolved three-level select input. A flag held inside the mode register decides whether the third level is honoured. The block never returns data. It answers only through the ACK slot, which it pulls low selectively. The multiplexer select combines a fast external pin with a register flag, so that switching can happen without bus traffic.

Top module: `vbuf_cfg_i2c`

## Requirements
- R1: After reset the cutoff code is 7Dh, the address-count flag is 1, every other register bit is 0, every channel type reads clamp (00) and SDA is not pulled low.
- R2: The address-select input is encoded 00 = low level, 01 = high level, 10 = open level, 11 = no level. The 7-bit device address is 48h for 00, 49h for 01 and 4Ah for 10. Code 11 matches no address.
- R3: The address byte is acknowledged (SDA pulled low in the ninth clock) only when its upper seven bits equal the device address and bit 0 (R/W) is 0. Otherwise every later slot of that frame is left high and no register changes.
- R4: When the address-count flag (mode register bit 2) is 0, select code 10 matches no address, so a device on that level cannot be reached again until the select input changes.
- R5: The register index byte is acknowledged only for indices 01h (cutoff code), 02h (input/gain) and 03h (mode).
- R6: The data byte is always acknowledged after a matched address, whatever its value. If the index was not valid, the data is discarded.
- R7: Register 02h: bits 7:2 hold the channel type fields and bit 0 is the gain select. Register 03h: bit 7 power-down, bit 6 multiplexer flag, bit 5 half cutoff, bit 4 filter bypass, bit 2 address-count flag. Unused bits read as 0.
- R8: The channel type fields are register 02h bits 7:6 (channel 1), 5:4 (channel 2) and 3:2 (channel 3). A field of 00 gives clamp, 01 gives bias and 1x gives direct. The type output carries channel n in bits 2n-1:2n-2, coded 00 clamp, 01 bias, 10 direct.
- R9: The multiplexer select output is 1 (input B) when the external pin is high, or when the pin is low and the multiplexer flag is 1. Otherwise it is 0 (input A).
- R10: The index does not auto-increment. Any byte after the data byte is not acknowledged and changes nothing.
- R11: A START inside a frame abandons it and restarts address reception. A STOP before the data byte is complete leaves all registers unchanged.
- R12: A register takes its new value only when SCL falls at the end of the data byte's ACK slot. During that slot the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain ACK) |
| addr_sel | input | 2 | Resolved address-select level (00 low, 01 high, 10 open, 11 none) |
| mux_pin | input | 1 | External multiplexer override pin |
| cutoff_code | output | 8 | Filter cutoff code |
| chan_type | output | 6 | Decoded input type, 2 bits per channel |
| gain_sel | output | 1 | Output gain select |
| power_down | output | 1 | Analog power-down |
| half_fc | output | 1 | Half cutoff on channels 2 and 3 |
| bypass | output | 1 | Filter bypass |
| mux_sel_b | output | 1 | Effective multiplexer select, 1 = input B |

## Verification
The bench targets several specific failure modes. It sends frames to the open select level after clearing the address-count flag; a decoder that ignored the flag would keep acknowledging and the device would never lock out. It sends unknown indices and expects a NACK followed by an acknowledged but discarded data byte; a design that dropped the frame early, or wrote anyway, shows up in the ACK pattern or the registers. Frames with a fourth byte, a restart in the middle of the address byte, and a STOP inside the data byte each catch auto-increment, a missed resynchronisation, or a partial commit. Registers are also sampled during the data ACK slot, which exposes a commit made too early.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_SHIFT, RX_ACK, RX_SKIP} rx_state_e;

    localparam logic [1:0] SEL_LOW  = 2'd0;
    localparam logic [1:0] SEL_HIGH = 2'd1;
    localparam logic [1:0] SEL_OPEN = 2'd2;

    localparam logic [7:0] IDX_CUTOFF = 8'h01;
    localparam logic [7:0] IDX_INPUT  = 8'h02;
    localparam logic [7:0] IDX_MODE   = 8'h03;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/vcfg_sync.sv
module vcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] scl;
        logic [PW-1:0] sda;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d     = q;
        d.scl = {q.scl[PW-2:0], scl_i};
        d.sda = {q.sda[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: '1, sda: '1};
        else        q <= d;
    end

    logic scl_prev, sda_prev;
    assign scl_s    = q.scl[STAGES-1];
    assign sda_s    = q.sda[STAGES-1];
    assign scl_prev = q.scl[STAGES];
    assign sda_prev = q.sda[STAGES];

    assign scl_rise = scl_s & ~scl_prev;
    assign scl_fall = ~scl_s & scl_prev;
    assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/vcfg_rx.sv
module vcfg_rx
    import vcfg_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic [1:0] addr_sel,
    input  logic       allow3,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        rx_state_e          state;
        logic [BYTE_W-1:0]  sr;
        logic [CNT_W-1:0]   bitcnt;
        logic [1:0]         byte_no;
        logic [BYTE_W-1:0]  idx;
        logic               idx_ok;
        logic               oe;
        logic               wr;
    } rx_t;

    rx_t d, q;

    logic       addr_hit;
    logic       idx_valid;
    logic [6:0] own_addr;
    logic       sel_ok;

    always_comb begin
        own_addr = DEV_BASE | {5'd0, addr_sel};
        unique case (addr_sel)
            SEL_LOW, SEL_HIGH: sel_ok = 1'b1;
            SEL_OPEN:          sel_ok = allow3;
            default:           sel_ok = 1'b0;
        endcase
        addr_hit  = sel_ok && (q.sr[7:1] == own_addr) && !q.sr[0];
        idx_valid = (q.sr == IDX_CUTOFF) || (q.sr == IDX_INPUT) || (q.sr == IDX_MODE);
    end

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (start_p) begin
            d.state   = RX_SHIFT;
            d.bitcnt  = '0;
            d.byte_no = 2'd0;
            d.idx_ok  = 1'b0;
            d.oe      = 1'b0;
        end else if (stop_p) begin
            d.state = RX_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                RX_SHIFT: begin
                    if (scl_rise) begin
                        d.sr     = {q.sr[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && q.bitcnt == CNT_W'(BYTE_W)) begin
                        d.bitcnt = '0;
                        d.state  = RX_ACK;
                        unique case (q.byte_no)
                            2'd0:    d.oe = addr_hit;
                            2'd1: begin
                                d.oe     = idx_valid;
                                d.idx    = q.sr;
                                d.idx_ok = idx_valid;
                            end
                            default: d.oe = 1'b1;
                        endcase
                    end
                end
                RX_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (q.byte_no == 2'd2) begin
                            d.wr    = q.idx_ok;
                            d.state = RX_SKIP;
                        end else if (q.byte_no == 2'd0 && !q.oe) begin
                            d.state = RX_SKIP;
                        end else begin
                            d.byte_no = q.byte_no + 2'd1;
                            d.state   = RX_SHIFT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: RX_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr;
    assign wr_idx  = q.idx;
    assign wr_data = q.sr;

    AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.state == RX_ACK);                                    // R6
    AST_ACK_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(q.oe));                     // R6
    AST_OPEN_LEVEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_ACK && q.byte_no == 2'd0 && q.oe)
            |-> !(addr_sel == SEL_OPEN && !allow3));                    // R4
    AST_BAD_INDEX_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_ACK && q.byte_no == 2'd1 && q.oe)
            |-> (q.idx >= IDX_CUTOFF && q.idx <= IDX_MODE));            // R5
    AST_WRITE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.state == RX_SKIP && q.byte_no == 2'd2));            // R12
endmodule

// File: rtl/vcfg_regs.sv
module vcfg_regs
    import vcfg_pkg::*;
#(
    parameter logic [7:0] CUT_RST = 8'h7D,
    parameter int         NUM_CH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_idx,
    input  logic [7:0]          wr_data,
    input  logic                mux_pin,
    output logic [7:0]          cutoff_code,
    output logic [2*NUM_CH-1:0] chan_type,
    output logic                gain_sel,
    output logic                power_down,
    output logic                half_fc,
    output logic                bypass,
    output logic                mux_sel_b,
    output logic                allow3
);
    localparam logic [7:0] INPUT_MASK = 8'hFD;
    localparam logic [7:0] MODE_MASK  = 8'hF4;
    localparam logic [7:0] MODE_RST   = 8'h04;

    typedef struct packed {
        logic [7:0] cut;
        logic [7:0] inp;
        logic [7:0] mode;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (wr_idx)
                IDX_CUTOFF: d.cut  = wr_data;
                IDX_INPUT:  d.inp  = wr_data & INPUT_MASK;
                IDX_MODE:   d.mode = wr_data & MODE_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cut: CUT_RST, inp: 8'h00, mode: MODE_RST};
        else        q <= d;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_type
        logic [1:0] fld;
        assign fld = q.inp[7-2*ch -: 2];
        assign chan_type[2*ch +: 2] = fld[1] ? 2'b10 : fld;
    end

    assign cutoff_code = q.cut;
    assign gain_sel    = q.inp[0];
    assign power_down  = q.mode[7];
    assign half_fc     = q.mode[5];
    assign bypass      = q.mode[4];
    assign allow3      = q.mode[2];
    assign mux_sel_b   = mux_pin | q.mode[6];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));                                         // R12
endmodule

// File: rtl/vbuf_cfg_i2c.sv
module vbuf_cfg_i2c #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_BASE    = 7'h48,
    parameter logic [7:0] CUT_RST     = 8'h7D,
    parameter int         NUM_CH      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [1:0]          addr_sel,
    input  logic                mux_pin,
    output logic [7:0]          cutoff_code,
    output logic [2*NUM_CH-1:0] chan_type,
    output logic                gain_sel,
    output logic                power_down,
    output logic                half_fc,
    output logic                bypass,
    output logic                mux_sel_b
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic       wr_en, allow3;
    logic [7:0] wr_idx, wr_data;

    vcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    vcfg_rx #(.DEV_BASE(DEV_BASE)) u_rx (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .addr_sel(addr_sel), .allow3(allow3), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    vcfg_regs #(.CUT_RST(CUT_RST), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mux_pin(mux_pin), .cutoff_code(cutoff_code), .chan_type(chan_type),
        .gain_sel(gain_sel), .power_down(power_down), .half_fc(half_fc),
        .bypass(bypass), .mux_sel_b(mux_sel_b), .allow3(allow3)
    );
endmodule

// File: tb/tb_vbuf_cfg_i2c.sv
module tb_vbuf_cfg_i2c;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic       mux_pin = 1'b0;
    logic       sda_oe, sda_bus;
    logic [7:0] cutoff_code;
    logic [5:0] chan_type;
    logic       gain_sel, power_down, half_fc, bypass, mux_sel_b;

    assign sda_bus = m_sda & ~sda_oe;

    vbuf_cfg_i2c dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .mux_pin(mux_pin), .cutoff_code(cutoff_code),
        .chan_type(chan_type), .gain_sel(gain_sel), .power_down(power_down),
        .half_fc(half_fc), .bypass(bypass), .mux_sel_b(mux_sel_b)
    );

    int  checks = 0, fails = 0;
    bit  done = 1'b0;
    logic [7:0] m_cut = 8'h7D, m_inp = 8'h00, m_mode = 8'h04;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_types(input logic [7:0] inp);
        logic [5:0] r;
        for (int ch = 0; ch < 3; ch++) begin
            logic [1:0] f;
            f = inp[7-2*ch -: 2];
            r[2*ch +: 2] = f[1] ? 2'b10 : f;
        end
        return r;
    endfunction

    function automatic bit addr_ok(input logic [7:0] b0, input logic [1:0] sel, input logic nca);
        bit lvl;
        lvl = (sel == 2'd0) || (sel == 2'd1) || (sel == 2'd2 && nca);
        return lvl && (b0[7:1] == (7'h48 | {5'd0, sel})) && !b0[0];
    endfunction

    function automatic bit idx_ok(input logic [7:0] b1);
        return b1 >= 8'h01 && b1 <= 8'h03;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check_regs(input string ctx);
        chk(cutoff_code == m_cut, {"R7 cutoff ", ctx}, cutoff_code, m_cut);
        chk(chan_type == exp_types(m_inp), {"R8 types ", ctx}, chan_type, exp_types(m_inp));
        chk(gain_sel == m_inp[0], {"R7 gain ", ctx}, gain_sel, m_inp[0]);
        chk({power_down, half_fc, bypass} == {m_mode[7], m_mode[5], m_mode[4]},
            {"R7 mode ", ctx}, {power_down, half_fc, bypass}, {m_mode[7], m_mode[5], m_mode[4]});
        chk(mux_sel_b == (mux_pin | m_mode[6]), {"R9 mux ", ctx}, mux_sel_b, mux_pin | m_mode[6]);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        end
    endtask

    task automatic ack_slot(input bit data_slot, output logic a);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        a = (sda_bus == 1'b0);
        if (data_slot) check_regs("R12 old value during data ACK");
        wq(); m_scl = 1'b0; wq();
    endtask

    task automatic frame(input logic [7:0] b0, b1, b2, b3, input int n, input string ctx);
        logic [3:0] got, exp;
        logic [7:0] bs[4];
        bit a_ok;
        bs = '{b0, b1, b2, b3};
        a_ok = addr_ok(b0, addr_sel, m_mode[2]);
        exp = '0;
        if (a_ok) exp = {1'b0, n > 2, idx_ok(b1), 1'b1};
        for (int k = 0; k < 4; k++) if (k >= n) exp[k] = 1'b0;
        got = '0;
        do_start();
        for (int k = 0; k < n; k++) begin
            logic a;
            send_bits(bs[k], 8);
            ack_slot(k == 2, a);
            got[k] = a;
        end
        do_stop();
        chk(got == exp, {"R3 R5 R6 R10 ack pattern ", ctx}, got, exp);
        if (a_ok && idx_ok(b1) && n >= 3) begin
            case (b1)
                8'h01: m_cut = b2;
                8'h02: m_inp = b2 & 8'hFD;
                default: m_mode = b2 & 8'hF4;
            endcase
        end
        repeat (4) @(negedge clk);
        check_regs(ctx);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        chk(cutoff_code == 8'h7D, "R1 cutoff reset", cutoff_code, 8'h7D);
        check_regs("R1 reset");

        // R2: each select level maps to its address
        for (int s = 0; s < 3; s++) begin
            addr_sel = 2'(s);
            frame({7'h48 | 7'(s), 1'b0}, 8'h01, 8'h20 + 8'(s), 8'h00, 3, "R2 level");
        end
        addr_sel = 2'd3;
        frame(8'h90, 8'h01, 8'h55, 8'h00, 3, "R2 code 11 low addr");
        frame(8'h94, 8'h01, 8'h55, 8'h00, 3, "R2 code 11 open addr");

        // R3: wrong address, read bit
        addr_sel = 2'd0;
        frame(8'h92, 8'h01, 8'h66, 8'h00, 3, "R3 foreign address");
        frame(8'h91, 8'h01, 8'h66, 8'h00, 3, "R3 read bit");

        // R5 R6: invalid indices, data acked but discarded
        frame(8'h90, 8'h00, 8'hAA, 8'h00, 3, "R5 index 00");
        frame(8'h90, 8'h04, 8'hAA, 8'h00, 3, "R5 index 04");
        frame(8'h90, 8'hFF, 8'h00, 8'h00, 3, "R6 index FF zero data");

        // R7 R8: layouts and type decode
        frame(8'h90, 8'h02, 8'hA7, 8'h00, 3, "R8 direct direct bias");
        frame(8'h90, 8'h02, 8'h6C, 8'h00, 3, "R8 bias direct direct");
        frame(8'h90, 8'h02, 8'h14, 8'h00, 3, "R8 clamp bias bias");
        frame(8'h90, 8'h03, 8'hFF, 8'h00, 3, "R7 mode all ones");
        frame(8'h90, 8'h03, 8'h04, 8'h00, 3, "R7 mode cleared");

        // R9: pin and flag combinations
        mux_pin = 1'b1; repeat (2) @(negedge clk); check_regs("R9 pin high flag 0");
        mux_pin = 1'b0; repeat (2) @(negedge clk); check_regs("R9 pin low flag 0");
        frame(8'h90, 8'h03, 8'h44, 8'h00, 3, "R9 flag 1 pin low");
        mux_pin = 1'b1; repeat (2) @(negedge clk); check_regs("R9 pin high flag 1");
        mux_pin = 1'b0;

        // R10: fourth byte ignored
        frame(8'h90, 8'h01, 8'h3C, 8'hC3, 4, "R10 extra byte");

        // R11: restart inside address byte, then full frame
        do_start(); send_bits(8'h90, 4); do_start();
        send_bits(8'h90, 8);
        begin
            logic a0, a1, a2;
            ack_slot(1'b0, a0); send_bits(8'h01, 8); ack_slot(1'b0, a1);
            send_bits(8'h5A, 8); ack_slot(1'b1, a2);
            do_stop();
            chk({a2, a1, a0} == 3'b111, "R11 restart acks", {a2, a1, a0}, 3'b111);
        end
        m_cut = 8'h5A; repeat (4) @(negedge clk); check_regs("R11 restart applied");
        // R11: stop inside data byte
        do_start(); send_bits(8'h90, 8);
        begin
            logic a;
            ack_slot(1'b0, a); send_bits(8'h01, 8); ack_slot(1'b0, a);
        end
        send_bits(8'hE1, 4); do_stop();
        repeat (4) @(negedge clk); check_regs("R11 aborted data");

        // R4: open level lockout
        addr_sel = 2'd2;
        frame(8'h94, 8'h03, 8'h00, 8'h00, 3, "R4 clear count flag");
        frame(8'h94, 8'h01, 8'h11, 8'h00, 3, "R4 locked out");
        addr_sel = 2'd1;
        frame(8'h92, 8'h03, 8'h04, 8'h00, 3, "R4 restore via high level");
        addr_sel = 2'd2;
        frame(8'h94, 8'h01, 8'h22, 8'h00, 3, "R4 reachable again");

        // random traffic
        for (int t = 0; t < 50; t++) begin
            logic [7:0] b0, b1, b2;
            int n;
            addr_sel = 2'($urandom % 4);
            mux_pin  = 1'($urandom % 2);
            b0 = ($urandom % 4 != 0) ? {7'h48 | {5'd0, addr_sel}, 1'b0} : 8'($urandom);
            b1 = ($urandom % 5 != 0) ? 8'(1 + $urandom % 3) : 8'($urandom);
            b2 = 8'($urandom);
            if (b1 == 8'h03 && ($urandom % 4 != 0)) b2[2] = 1'b1;
            n = ($urandom % 6 == 0) ? 4 : 3;
            frame(b0, b1, b2, 8'($urandom), n, "random R6 R7");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule